// File: doc/BRIEF.md
# Multi-Channel PWM Timer with Staged Compare Values

This block is a free-running PWM timer with one period compare slot and six duty compare slots. Software writes compare values over a small synchronous register bus at any moment. Each written value sits in a staging register, and the comparators look only at a separate live copy. When the period match restarts the counter, a set of arm bits decides which staged values move into the live copies. All armed values change on the same clock edge, so a multi-channel update takes effect at a cycle boundary and every channel moves at once.

A prescaler sets how many clocks pass per count. A match configuration register chooses, for each compare slot, whether a match raises the interrupt pulse and whether it restarts the counter. A hold bit parks the counter and prescaler at zero. With the staged mode off, every staged value goes live at each counter restart and no arm bits are needed.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset all six outputs and the interrupt are low, and every register reads back as zero (match slots at addresses 0..6, count at address 11).
- R2: With slot 0 holding P and restart-on-slot-0 set, the count runs 0..P and restarts. Output n (1..6, live value S) is high from a restart until the step where the count equals S, so it is high for S+1 counts per period. S=0 keeps it low, and S>=P keeps it high.
- R3: With prescale value Q (address 9), the count advances once every Q+1 clocks. Q=0 advances it on every clock.
- R4: In staged mode (control bit 2 at address 8), writing a match slot whose arm bit is clear leaves the outputs unchanged across later periods.
- R5: In staged mode, a slot-0 match that restarts the counter copies every armed slot into its live copy on one edge and clears those arm bits. Writing ones to address 7 sets arm bits 6..0, writing zeros has no effect, and a read returns the arm bits.
- R6: If software sets an arm bit on the same edge that a transfer clears it, the bit stays set for the next period.
- R7: With staged mode off, a newly written match value takes effect at the next counter restart without any arm bit.
- R8: While the hold bit (control bit 1) is set, the count reads zero and all outputs are low. Control bit 0 lets the timer run.
- R9: Address 10 holds, for slot n, interrupt-enable in bit n and restart-enable in bit 8+n. Each match with interrupt enabled gives a one-clock interrupt pulse. A match with restart disabled does not change the period.
- R10: Reading a match slot returns the value software last wrote, not the live copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears after the next edge |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_o | output | 6 | Channel outputs, bit n-1 driven by slot n |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
The bench builds the block with its default parameters: six channels and a 32-bit counter. Short periods of 5 to 11 counts and prescale values up to 2 keep every period small. Whole-period high counts can then be measured in a few dozen clocks, including the constant-low, constant-high and slot-equals-period cases. The short period also lets the bench align a write with the restart edge after an interrupt pulse, which is how it exercises the case where a software arm and a hardware clear land on the same edge.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned MCFG_RST = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_ARM      = 4'd7,
    REG_CTRL     = 4'd8,
    REG_PRESCALE = 4'd9,
    REG_MCFG     = 4'd10,
    REG_COUNT    = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic staged;
    logic hold;
    logic run;
  } ctrl_t;

  // Level an output takes when a new period begins with live value v.
  function automatic logic start_level(input logic [DATA_W-1:0] v);
    return v != '0;
  endfunction

  // True when an address selects one of n match slots.
  function automatic logic is_match_slot(input logic [ADDR_W-1:0] a,
                                         input int unsigned n);
    return 32'(a) < n;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned NUM_MATCH = 7,
  parameter int unsigned CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic [CNT_W-1:0]           count,
  input  logic                       arm_clr,
  output logic [NUM_MATCH*CNT_W-1:0] match_flat,
  output logic [NUM_MATCH-1:0]       arm_mask,
  output ctrl_t                      ctrl,
  output logic [CNT_W-1:0]           prescale,
  output logic [NUM_MATCH-1:0]       cfg_irq,
  output logic [NUM_MATCH-1:0]       cfg_rst
);

  logic [CNT_W-1:0]     match_q [NUM_MATCH];
  logic [NUM_MATCH-1:0] arm_set;
  logic [DATA_W-1:0]    rd_val;

  // Software set is applied after the hardware clear, so it wins.
  function automatic logic [NUM_MATCH-1:0] next_arm(
    input logic [NUM_MATCH-1:0] cur,
    input logic                 clr,
    input logic [NUM_MATCH-1:0] set
  );
    return (clr ? '0 : cur) | set;
  endfunction

  generate
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          match_q[i] <= '0;
        end else if (wr_en && addr == ADDR_W'(i)) begin
          match_q[i] <= wdata[CNT_W-1:0];
        end
      end
      assign match_flat[i*CNT_W +: CNT_W] = match_q[i];
    end
  endgenerate

  assign arm_set = (wr_en && addr == REG_ARM) ? wdata[NUM_MATCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_mask <= '0;
    end else begin
      arm_mask <= next_arm(arm_mask, arm_clr, arm_set);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      prescale <= '0;
      cfg_irq  <= '0;
      cfg_rst  <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_CTRL:     ctrl     <= ctrl_t'(wdata[2:0]);
        REG_PRESCALE: prescale <= wdata[CNT_W-1:0];
        REG_MCFG: begin
          cfg_irq <= wdata[NUM_MATCH-1:0];
          cfg_rst <= wdata[MCFG_RST +: NUM_MATCH];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    if (is_match_slot(addr, NUM_MATCH)) begin
      for (int i = 0; i < NUM_MATCH; i++) begin
        if (addr == ADDR_W'(i)) rd_val = DATA_W'(match_q[i]);
      end
    end else begin
      case (addr)
        REG_ARM:      rd_val[NUM_MATCH-1:0] = arm_mask;
        REG_CTRL:     rd_val[2:0] = ctrl;
        REG_PRESCALE: rd_val = DATA_W'(prescale);
        REG_MCFG: begin
          rd_val[NUM_MATCH-1:0]           = cfg_irq;
          rd_val[MCFG_RST +: NUM_MATCH]   = cfg_rst;
        end
        REG_COUNT:    rd_val = DATA_W'(count);
        default:      rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_val;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned NUM_MATCH = 7,
  parameter int unsigned CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrl_t                      ctrl,
  input  logic [CNT_W-1:0]           prescale,
  input  logic [NUM_MATCH-1:0]       cfg_irq,
  input  logic [NUM_MATCH-1:0]       cfg_rst,
  input  logic [NUM_MATCH-1:0]       arm_mask,
  input  logic [NUM_MATCH*CNT_W-1:0] shadow_flat,
  output logic [CNT_W-1:0]           count,
  output logic                       cnt_step,
  output logic [NUM_MATCH-1:0]       hit,
  output logic                       cyc_start,
  output logic                       load_evt,
  output logic [NUM_MATCH-1:0]       load_mask,
  output logic                       arm_clr,
  output logic                       irq_hit,
  output logic                       irq_o
);

  logic [CNT_W-1:0] pre_q;
  logic             pre_wrap;

  assign pre_wrap = pre_q >= prescale;
  assign cnt_step = ctrl.run && !ctrl.hold && pre_wrap;

  generate
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
      assign hit[i] = cnt_step && (count == shadow_flat[i*CNT_W +: CNT_W]);
    end
  endgenerate

  assign cyc_start = |(hit & cfg_rst);
  assign load_evt  = ctrl.staged ? (hit[0] && cfg_rst[0]) : cyc_start;
  assign load_mask = ctrl.staged ? arm_mask : '1;
  assign arm_clr   = load_evt && ctrl.staged;
  assign irq_hit   = |(hit & cfg_irq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (ctrl.hold) begin
      pre_q <= '0;
    end else if (ctrl.run) begin
      pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ctrl.hold) begin
      count <= '0;
    end else if (cnt_step) begin
      count <= cyc_start ? '0 : count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_hit;
  end

endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
  parameter int unsigned NUM_MATCH = 7,
  parameter int unsigned CNT_W     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load_evt,
  input  logic [NUM_MATCH-1:0]           load_mask,
  input  logic [NUM_MATCH*CNT_W-1:0]     match_flat,
  output logic [NUM_MATCH*CNT_W-1:0]     shadow_flat,
  output logic [(NUM_MATCH-1)*CNT_W-1:0] chan_nxt_flat
);

  logic [NUM_MATCH*CNT_W-1:0] nxt_flat;

  generate
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_slot
      assign nxt_flat[i*CNT_W +: CNT_W] = (load_evt && load_mask[i])
                                          ? match_flat[i*CNT_W +: CNT_W]
                                          : shadow_flat[i*CNT_W +: CNT_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_flat[i*CNT_W +: CNT_W] <= '0;
        else        shadow_flat[i*CNT_W +: CNT_W] <= nxt_flat[i*CNT_W +: CNT_W];
      end
    end
  endgenerate

  assign chan_nxt_flat = nxt_flat[NUM_MATCH*CNT_W-1:CNT_W];

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             cyc_start,
  input  logic             hit,
  input  logic [CNT_W-1:0] start_val,
  output logic             out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out <= 1'b0;
    end else if (hold) begin
      out <= 1'b0;
    end else if (cyc_start) begin
      out <= start_level(DATA_W'(start_val));
    end else if (hit) begin
      out <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
  import pwm_shadow_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);

  localparam int unsigned NUM_MATCH = NUM_CH + 1;

  logic [NUM_MATCH*CNT_W-1:0] match_flat;
  logic [NUM_MATCH*CNT_W-1:0] shadow_flat;
  logic [NUM_CH*CNT_W-1:0]    chan_nxt_flat;
  logic [NUM_MATCH-1:0]       arm_mask;
  logic [NUM_MATCH-1:0]       cfg_irq;
  logic [NUM_MATCH-1:0]       cfg_rst;
  logic [NUM_MATCH-1:0]       hit;
  logic [NUM_MATCH-1:0]       load_mask;
  logic [CNT_W-1:0]           prescale;
  logic [CNT_W-1:0]           count;
  ctrl_t                      ctrl;
  logic                       cnt_step;
  logic                       cyc_start;
  logic                       load_evt;
  logic                       arm_clr;
  logic                       irq_hit;

  pwm_regs #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .count      (count),
    .arm_clr    (arm_clr),
    .match_flat (match_flat),
    .arm_mask   (arm_mask),
    .ctrl       (ctrl),
    .prescale   (prescale),
    .cfg_irq    (cfg_irq),
    .cfg_rst    (cfg_rst)
  );

  pwm_timebase #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .prescale    (prescale),
    .cfg_irq     (cfg_irq),
    .cfg_rst     (cfg_rst),
    .arm_mask    (arm_mask),
    .shadow_flat (shadow_flat),
    .count       (count),
    .cnt_step    (cnt_step),
    .hit         (hit),
    .cyc_start   (cyc_start),
    .load_evt    (load_evt),
    .load_mask   (load_mask),
    .arm_clr     (arm_clr),
    .irq_hit     (irq_hit),
    .irq_o       (irq_o)
  );

  pwm_shadow_bank #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_shadow (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_evt      (load_evt),
    .load_mask     (load_mask),
    .match_flat    (match_flat),
    .shadow_flat   (shadow_flat),
    .chan_nxt_flat (chan_nxt_flat)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_chan #(.CNT_W(CNT_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (ctrl.hold),
        .cyc_start (cyc_start),
        .hit       (hit[c+1]),
        .start_val (chan_nxt_flat[c*CNT_W +: CNT_W]),
        .out       (pwm_o[c])
      );
    end
  endgenerate

endmodule

// File: rtl/pwm_shadow_timer_chk.sv
module pwm_shadow_timer_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CNT_W  = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [3:0]                  addr,
  input logic                        staged,
  input logic                        hold,
  input logic                        load_evt,
  input logic                        cyc_start,
  input logic                        cnt_step,
  input logic                        irq_hit,
  input logic                        irq_o,
  input logic [NUM_CH:0]             arm_mask,
  input logic [CNT_W-1:0]            count,
  input logic [(NUM_CH+1)*CNT_W-1:0] shadow_flat,
  input logic [NUM_CH-1:0]           pwm_o
);

  AST_LIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(shadow_flat)); // R4

  AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && staged && !(wr_en && addr == 4'd7)) |=> (arm_mask == '0)); // R5

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0 && pwm_o == '0)); // R8

  AST_COUNT_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_step && !hold) |=> $stable(count)); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(irq_hit)); // R9

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl
      AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> (pwm_o[c] == (shadow_flat[(c+1)*CNT_W +: CNT_W] != '0))); // R2
    end
  endgenerate

endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .staged      (ctrl.staged),
  .hold        (ctrl.hold),
  .load_evt    (load_evt),
  .cyc_start   (cyc_start),
  .cnt_step    (cnt_step),
  .irq_hit     (irq_hit),
  .irq_o       (irq_o),
  .arm_mask    (arm_mask),
  .count       (count),
  .shadow_flat (shadow_flat),
  .pwm_o       (pwm_o)
);

// File: tb/test_pwm_shadow_timer.sv
`timescale 1ns/1ps
module test_pwm_shadow_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pwm_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int hi_cnt [6];
  int irq_cnt;
  logic [31:0] rv;

  always #5 clk = ~clk;

  pwm_shadow_timer i_pwm_shadow_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [7:0]  pre;
    logic [7:0]  per;
    logic [47:0] duty;  // byte k is channel k+1
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{pre: 8'd0, per: 8'd4,  duty: {8'd9, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0}},
    '{pre: 8'd1, per: 8'd7,  duty: {8'd8, 8'd1, 8'd5, 8'd7, 8'd0, 8'd3}},
    '{pre: 8'd2, per: 8'd5,  duty: {8'd3, 8'd4, 8'd1, 8'd0, 8'd6, 8'd2}},
    '{pre: 8'd0, per: 8'd10, duty: {8'd9, 8'd1, 8'd0, 8'd11, 8'd10, 8'd5}}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count high samples per channel and interrupt pulses over n clocks.
  task automatic measure(input int n);
    for (int k = 0; k < 6; k++) hi_cnt[k] = 0;
    irq_cnt = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      for (int k = 0; k < 6; k++) if (pwm_o[k]) hi_cnt[k]++;
      if (irq_o) irq_cnt++;
    end
  endtask

  // High clocks expected in np periods, derived from the duty rule.
  function automatic int want_high(input int s, input int per, input int pre, input int np);
    int counts;
    if (s == 0)        counts = 0;
    else if (s >= per) counts = per + 1;
    else               counts = s + 1;
    return counts * (pre + 1) * np;
  endfunction

  task automatic setup(input int pre, input int per, input logic [47:0] duty,
                       input logic [31:0] mcfg);
    wr(4'd8, 32'h2);
    wr(4'd9, 32'(pre));
    wr(4'd0, 32'(per));
    for (int k = 0; k < 6; k++) wr(4'(k + 1), 32'(duty[k*8 +: 8]));
    wr(4'd10, mcfg);
    wr(4'd7, 32'h7F);
    wr(4'd8, 32'h5);
    idle(250);
  endtask

  initial begin
    #(100000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    check("R1 outputs", int'(pwm_o), 0);
    check("R1 irq", int'(irq_o), 0);
    rd(4'd3, rv);  check("R1 match3", int'(rv), 0);
    rd(4'd11, rv); check("R1 count", int'(rv), 0);

    // R2 R3 R9: table of periods, prescales and duty values
    foreach (VECS[v]) begin
      int p, q, win;
      q = int'(VECS[v].pre);
      p = int'(VECS[v].per);
      win = 4 * (p + 1) * (q + 1);
      setup(q, p, VECS[v].duty, 32'h0000_0101);
      measure(win);
      for (int k = 0; k < 6; k++)
        check($sformatf("R2/R3 vec%0d ch%0d", v, k + 1), hi_cnt[k],
              want_high(int'(VECS[v].duty[k*8 +: 8]), p, q, 4));
      check($sformatf("R9 vec%0d irq", v), irq_cnt, 4);
    end

    // Staged mode, period 5 counts, all channels at 2
    setup(0, 4, {6{8'd2}}, 32'h0000_0101);

    // R10 and R4: unarmed write reads back but does not reach the output
    wr(4'd1, 32'd3);
    rd(4'd1, rv); check("R10 readback", int'(rv), 3);
    idle(15);
    measure(20);
    check("R4 ch1 unchanged", hi_cnt[0], 12);
    rd(4'd7, rv); check("R5 arm idle", int'(rv), 0);

    // R5: arming one slot transfers it and clears the bit
    wr(4'd7, 32'h2);
    idle(15);
    measure(20);
    check("R5 ch1 loaded", hi_cnt[0], 16);
    rd(4'd7, rv); check("R5 arm cleared", int'(rv), 0);

    // R5: two slots armed together both change
    wr(4'd2, 32'd0);
    wr(4'd3, 32'd9);
    wr(4'd7, 32'h0C);
    idle(15);
    measure(20);
    check("R5 ch2 loaded", hi_cnt[1], 0);
    check("R5 ch3 loaded", hi_cnt[2], 20);

    // R6: software arm on the same edge as the transfer clear
    wr(4'd4, 32'd0);
    for (int g = 0; g < 20 && !irq_o; g++) @(negedge clk);
    wr_en = 1'b1; addr = 4'd7; wdata = 32'h10;
    @(negedge clk); wr_en = 1'b0;
    idle(3);
    wr_en = 1'b1; addr = 4'd7; wdata = 32'h10;
    @(negedge clk); wr_en = 1'b0;
    rd(4'd7, rv); check("R6 arm survives", int'(rv), 32'h10);
    idle(12);
    rd(4'd7, rv); check("R6 arm later cleared", int'(rv), 0);
    measure(20);
    check("R6 ch4 loaded", hi_cnt[3], 0);

    // R9: interrupt on slot 1 without restart keeps the period
    wr(4'd10, 32'h0000_0103);
    idle(5);
    measure(20);
    check("R9 irq doubled", irq_cnt, 8);
    check("R9 ch1 period kept", hi_cnt[0], 16);
    wr(4'd10, 32'h0000_0101);

    // R7: staged mode off, value goes live at the next restart
    wr(4'd8, 32'h1);
    wr(4'd5, 32'd4);
    idle(15);
    measure(20);
    check("R7 ch5 live", hi_cnt[4], 20);
    rd(4'd7, rv); check("R7 arm untouched", int'(rv), 0);

    // R8: hold parks the counter and outputs
    wr(4'd8, 32'h3);
    idle(5);
    rd(4'd11, rv); check("R8 count held", int'(rv), 0);
    idle(7);
    rd(4'd11, rv); check("R8 count still held", int'(rv), 0);
    check("R8 outputs low", int'(pwm_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule